// File: doc/BRIEF.md
# Dyadic Operand Matching Store

This block sits between the token decoder and the execute stage of a dataflow processing element. Every incoming token carries a class bit (dyadic or monadic), a port bit, an instruction offset, a frame index and a 16-bit operand. A monadic token needs no partner, so it is forwarded at once as a single operand. A dyadic token addresses one of the first eight instruction offsets of its activation. The first operand to arrive for a given frame and offset is parked in the frame slot numbered by that offset, and a presence bit is set. When the operand for the other port arrives, both operands leave together, and the entry becomes empty again.

The storage is indexed directly by frame and offset, so no tag compare and no search is involved. The only guard against stale tokens is the presence bit of each entry. The frame allocator clears all presence bits of a frame when it releases that frame, which lets the frame be reused at once. Illegal traffic raises a one-cycle error flag and changes no state: a second operand on a port that is already waiting, or a dyadic token whose offset is outside the matchable range.

Top module: `operand_match_store`

## Requirements
- R1: After synchronous active-low reset, `out_valid`, `err_collision` and `err_offset` are 0 and every entry is empty, so the first dyadic operand sent to any frame and offset is stored and produces no output.
- R2: A token with `in_dyadic`=0 produces, one cycle later, `out_valid`=1, `out_pair`=0, `out_left`=its data, and `out_offset`/`out_frame` equal to its own, whatever its offset and whatever the presence state.
- R3: A dyadic token (`in_dyadic`=1) with offset below 8 that finds its entry empty is stored with its port, and it produces neither an output nor an error.
- R4: A dyadic token that finds its entry holding an operand from the other port produces, one cycle later, `out_valid`=1 and `out_pair`=1, with `out_left` set to the port-0 (`in_port`=0) operand and `out_right` set to the port-1 operand whatever the arrival order, and with the token's offset and frame. The entry then becomes empty.
- R5: A dyadic token that finds its entry holding an operand from the same port raises `err_collision` for one cycle, produces no output, and leaves the waiting operand unchanged.
- R6: A dyadic token with offset 8 or above raises `err_offset` for one cycle, produces no output and stores nothing.
- R7: Entries of different frames at the same offset are independent: operands for frame A never pair with operands for frame B.
- R8: `free_valid` empties all eight entries of `free_frame`. A token for that frame in the same cycle is first handled normally, and any store it makes is then removed.
- R9: All results appear exactly one cycle after the token. At most one of `out_valid`, `err_collision` and `err_offset` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Token present this cycle |
| in_dyadic | input | 1 | 1 = dyadic token, 0 = monadic |
| in_port | input | 1 | Operand port, 0 = left, 1 = right |
| in_offset | input | 8 | Instruction offset |
| in_frame | input | 2 | Frame index |
| in_data | input | 16 | Operand value |
| free_valid | input | 1 | Release the frame given by free_frame |
| free_frame | input | 2 | Frame being released |
| out_valid | output | 1 | Operand(s) ready for execute |
| out_pair | output | 1 | 1 = two operands, 0 = single operand |
| out_offset | output | 8 | Instruction offset of the output |
| out_frame | output | 2 | Frame index of the output |
| out_left | output | 16 | Port-0 operand, or the single operand |
| out_right | output | 16 | Port-1 operand; 0 when single |
| err_collision | output | 1 | Same-port operand hit an occupied entry |
| err_offset | output | 1 | Dyadic token outside the matchable offsets |

## Verification
The bench uses the default parameters: four frames, eight matchable slots, an 8-bit offset and 16-bit data. The whole store is then only 32 entries, and random offsets drawn from 0 to 9 revisit each entry often enough to produce many stores, reversed-order pairs and same-port collisions. Because the offset field is 8 bits wide, directed tokens can reach the boundaries exactly: offset 7 is the last matchable slot, offsets 8 and 255 must be rejected, and monadic tokens at high offsets must pass through. Random frame releases interleave with live entries, including releases that land in the same cycle as a store to the same frame.

// File: rtl/opmatch_pkg.sv
// Package: shared types for the operand matching store.
// Holds the per-token action code that the classifier hands to the datapath.
package opmatch_pkg;

    // Action decided for the token presented in the current cycle.
    typedef enum logic [2:0] {
        ACT_IDLE    = 3'd0,   // no token
        ACT_PASS    = 3'd1,   // monadic, forwarded alone
        ACT_STORE   = 3'd2,   // first dyadic operand, parked
        ACT_PAIR    = 3'd3,   // partner found, pair released
        ACT_COLLIDE = 3'd4,   // same port already waiting
        ACT_BADOFF  = 3'd5    // dyadic offset outside matchable range
    } match_act_e;

endpackage

// File: rtl/om_classify.sv
// Module: om_classify
// Decides, combinationally, what happens to the token presented this cycle.
// Assumes present/stored_port are already read for the token's frame and slot;
// they are ignored unless the token is dyadic and its offset is matchable.
module om_classify
    import opmatch_pkg::*;
#(
    parameter int SLOTS    = 8,
    parameter int OFFSET_W = 8
) (
    input  logic                in_valid,
    input  logic                in_dyadic,
    input  logic                in_port,
    input  logic [OFFSET_W-1:0] in_offset,
    input  logic                present,
    input  logic                stored_port,
    output match_act_e          act
);
    localparam logic [OFFSET_W-1:0] SLOT_LIMIT = OFFSET_W'(SLOTS);

    // Priority: idle, monadic, range check, empty entry, partner, collision.
    always_comb begin
        if (!in_valid)                    act = ACT_IDLE;
        else if (!in_dyadic)              act = ACT_PASS;
        else if (in_offset >= SLOT_LIMIT) act = ACT_BADOFF;
        else if (!present)                act = ACT_STORE;
        else if (stored_port != in_port)  act = ACT_PAIR;
        else                              act = ACT_COLLIDE;
    end

endmodule

// File: rtl/om_presence.sv
// Module: om_presence
// One presence bit per frame and matchable slot. Set on store, cleared on
// pair; a frame release clears the whole row and wins over a same-cycle set.
// Assumes wr_frame/free_frame/rd_frame are below FRAMES.
module om_presence #(
    parameter int FRAMES = 4,
    parameter int SLOTS  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       set_en,
    input  logic                       clr_en,
    input  logic [$clog2(FRAMES)-1:0]  wr_frame,
    input  logic [$clog2(SLOTS)-1:0]   wr_slot,
    input  logic                       free_en,
    input  logic [$clog2(FRAMES)-1:0]  free_frame,
    input  logic [$clog2(FRAMES)-1:0]  rd_frame,
    input  logic [$clog2(SLOTS)-1:0]   rd_slot,
    output logic                       present
);
    localparam int FRAME_W = $clog2(FRAMES);

    logic [SLOTS-1:0] rows [FRAMES];

    for (genvar f = 0; f < FRAMES; f++) begin : g_row
        logic [SLOTS-1:0] row_q;
        logic [SLOTS-1:0] row_nxt;
        logic             hit_wr;
        logic             hit_free;

        assign hit_wr   = (wr_frame   == FRAME_W'(f));
        assign hit_free = free_en && (free_frame == FRAME_W'(f));

        // Next row: apply set, then clear, then whole-row release.
        always_comb begin
            row_nxt = row_q;
            if (set_en && hit_wr) row_nxt[wr_slot] = 1'b1;
            if (clr_en && hit_wr) row_nxt[wr_slot] = 1'b0;
            if (hit_free)         row_nxt = '0;
        end

        // Row register, emptied by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) row_q <= '0;
            else        row_q <= row_nxt;
        end

        assign rows[f] = row_q;
    end

    assign present = rows[rd_frame][rd_slot];

endmodule

// File: rtl/om_operand_store.sv
// Module: om_operand_store
// Holds the waiting operand and its port for every frame/slot pair.
// No reset: contents are only meaningful while the presence bit is set.
module om_operand_store #(
    parameter int FRAMES = 4,
    parameter int SLOTS  = 8,
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic [$clog2(FRAMES)-1:0]  wr_frame,
    input  logic [$clog2(SLOTS)-1:0]   wr_slot,
    input  logic                       wr_port,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [$clog2(FRAMES)-1:0]  rd_frame,
    input  logic [$clog2(SLOTS)-1:0]   rd_slot,
    output logic                       rd_port,
    output logic [DATA_W-1:0]          rd_data
);
    localparam int ENTRIES = FRAMES * SLOTS;
    localparam int ADDR_W  = $clog2(ENTRIES);

    logic [DATA_W-1:0] data_mem [ENTRIES];
    logic              port_mem [ENTRIES];
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;

    assign wr_addr = ADDR_W'(wr_frame) * ADDR_W'(SLOTS) + ADDR_W'(wr_slot);
    assign rd_addr = ADDR_W'(rd_frame) * ADDR_W'(SLOTS) + ADDR_W'(rd_slot);

    // Capture the first operand and its port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_mem[wr_addr] <= wr_data;
            port_mem[wr_addr] <= wr_port;
        end
    end

    assign rd_data = data_mem[rd_addr];
    assign rd_port = port_mem[rd_addr];

endmodule

// File: rtl/operand_match_store.sv
// Module: operand_match_store (top)
// Pairs the two operands of dyadic instructions using direct-indexed frame
// slots and presence bits; forwards monadic tokens untouched. One register
// stage: every result appears the cycle after its token.
// Assumes the decoder has already split the token fields and that in_frame
// and free_frame name allocated frames.
module operand_match_store
    import opmatch_pkg::*;
#(
    parameter int FRAMES   = 4,
    parameter int SLOTS    = 8,
    parameter int OFFSET_W = 8,
    parameter int DATA_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_dyadic,
    input  logic                       in_port,
    input  logic [OFFSET_W-1:0]        in_offset,
    input  logic [$clog2(FRAMES)-1:0]  in_frame,
    input  logic [DATA_W-1:0]          in_data,
    input  logic                       free_valid,
    input  logic [$clog2(FRAMES)-1:0]  free_frame,
    output logic                       out_valid,
    output logic                       out_pair,
    output logic [OFFSET_W-1:0]        out_offset,
    output logic [$clog2(FRAMES)-1:0]  out_frame,
    output logic [DATA_W-1:0]          out_left,
    output logic [DATA_W-1:0]          out_right,
    output logic                       err_collision,
    output logic                       err_offset
);
    localparam int SLOT_W = $clog2(SLOTS);

    match_act_e        act;
    logic [SLOT_W-1:0] slot;
    logic              present;
    logic              stored_port;
    logic [DATA_W-1:0] stored_data;
    logic [DATA_W-1:0] pair_left;
    logic [DATA_W-1:0] pair_right;

    assign slot = in_offset[SLOT_W-1:0];

    om_presence #(.FRAMES(FRAMES), .SLOTS(SLOTS)) u_presence (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (act == ACT_STORE),
        .clr_en     (act == ACT_PAIR),
        .wr_frame   (in_frame),
        .wr_slot    (slot),
        .free_en    (free_valid),
        .free_frame (free_frame),
        .rd_frame   (in_frame),
        .rd_slot    (slot),
        .present    (present)
    );

    om_operand_store #(.FRAMES(FRAMES), .SLOTS(SLOTS), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .wr_en    (act == ACT_STORE),
        .wr_frame (in_frame),
        .wr_slot  (slot),
        .wr_port  (in_port),
        .wr_data  (in_data),
        .rd_frame (in_frame),
        .rd_slot  (slot),
        .rd_port  (stored_port),
        .rd_data  (stored_data)
    );

    om_classify #(.SLOTS(SLOTS), .OFFSET_W(OFFSET_W)) u_classify (
        .in_valid    (in_valid),
        .in_dyadic   (in_dyadic),
        .in_port     (in_port),
        .in_offset   (in_offset),
        .present     (present),
        .stored_port (stored_port),
        .act         (act)
    );

    // Order the pair by port: port 0 goes left whatever arrived first.
    always_comb begin
        if (in_port) begin
            pair_left  = stored_data;
            pair_right = in_data;
        end else begin
            pair_left  = in_data;
            pair_right = stored_data;
        end
    end

    // Output stage: register the result of this cycle's token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_pair      <= 1'b0;
            out_offset    <= '0;
            out_frame     <= '0;
            out_left      <= '0;
            out_right     <= '0;
            err_collision <= 1'b0;
            err_offset    <= 1'b0;
        end else begin
            out_valid     <= (act == ACT_PASS) || (act == ACT_PAIR);
            out_pair      <= (act == ACT_PAIR);
            err_collision <= (act == ACT_COLLIDE);
            err_offset    <= (act == ACT_BADOFF);
            out_offset    <= in_offset;
            out_frame     <= in_frame;
            out_left      <= (act == ACT_PAIR) ? pair_left  : in_data;
            out_right     <= (act == ACT_PAIR) ? pair_right : '0;
        end
    end

endmodule

// File: rtl/om_checker.sv
// Module: om_checker
// Temporal properties of the matching store, attached to the top by bind.
module om_checker #(
    parameter int SLOTS    = 8,
    parameter int OFFSET_W = 8,
    parameter int DATA_W   = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_dyadic,
    input logic                in_port,
    input logic [OFFSET_W-1:0] in_offset,
    input logic [DATA_W-1:0]   in_data,
    input logic                out_valid,
    input logic                out_pair,
    input logic [OFFSET_W-1:0] out_offset,
    input logic [DATA_W-1:0]   out_left,
    input logic [DATA_W-1:0]   out_right,
    input logic                err_collision,
    input logic                err_offset
);
    localparam logic [OFFSET_W-1:0] SLOT_LIMIT = OFFSET_W'(SLOTS);

    p_single_from_monadic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_pair |-> $past(in_valid && !in_dyadic)
            && out_left == $past(in_data) && out_offset == $past(in_offset));

    p_pair_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_pair |-> $past(in_valid && in_dyadic) && out_offset < SLOT_LIMIT);

    p_pair_port_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_pair |->
            ($past(in_port) ? out_right == $past(in_data) : out_left == $past(in_data)));

    p_collision_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_collision |-> $past(in_valid && in_dyadic && in_offset < SLOT_LIMIT));

    p_bad_offset_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_dyadic && in_offset >= SLOT_LIMIT) |-> err_offset && !out_valid);

    p_one_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, err_collision, err_offset}));

endmodule

bind operand_match_store om_checker #(
    .SLOTS(SLOTS), .OFFSET_W(OFFSET_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dyadic(in_dyadic),
    .in_port(in_port), .in_offset(in_offset), .in_data(in_data),
    .out_valid(out_valid), .out_pair(out_pair), .out_offset(out_offset),
    .out_left(out_left), .out_right(out_right),
    .err_collision(err_collision), .err_offset(err_offset)
);

// File: tb/operand_match_store_tb.sv
// Bench: directed corner cases plus seeded random traffic against a model.
module operand_match_store_tb;
    logic        clk = 0;
    logic        rst_n;
    logic        in_valid, in_dyadic, in_port, free_valid;
    logic [7:0]  in_offset;
    logic [1:0]  in_frame, free_frame;
    logic [15:0] in_data;
    logic        out_valid, out_pair, err_collision, err_offset;
    logic [7:0]  out_offset;
    logic [1:0]  out_frame;
    logic [15:0] out_left, out_right;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Model state.
    bit          m_pres [4][8];
    logic [15:0] m_data [4][8];
    bit          m_port [4][8];

    // Expected outputs for the token of the current cycle.
    bit          e_v, e_pair, e_col, e_bad;
    logic [7:0]  e_off;
    logic [1:0]  e_fr;
    logic [15:0] e_l, e_r;
    string       e_tag;

    always #5 clk = ~clk;

    operand_match_store u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dyadic(in_dyadic),
        .in_port(in_port), .in_offset(in_offset), .in_frame(in_frame),
        .in_data(in_data), .free_valid(free_valid), .free_frame(free_frame),
        .out_valid(out_valid), .out_pair(out_pair), .out_offset(out_offset),
        .out_frame(out_frame), .out_left(out_left), .out_right(out_right),
        .err_collision(err_collision), .err_offset(err_offset)
    );

    // Model one cycle from the requirements; sets e_* and updates state.
    function automatic void model(bit v, bit dy, bit p, logic [7:0] off,
                                  logic [1:0] fr, logic [15:0] d, bit fe, logic [1:0] ff);
        e_v = 0; e_pair = 0; e_col = 0; e_bad = 0;
        e_off = off; e_fr = fr; e_l = d; e_r = 0; e_tag = "R9";
        if (v) begin
            if (!dy) begin
                e_v = 1; e_tag = "R2";
            end else if (off >= 8) begin
                e_bad = 1; e_tag = "R6";
            end else if (!m_pres[fr][off[2:0]]) begin
                m_pres[fr][off[2:0]] = 1;
                m_data[fr][off[2:0]] = d;
                m_port[fr][off[2:0]] = p;
                e_tag = "R3";
            end else if (m_port[fr][off[2:0]] != p) begin
                e_v = 1; e_pair = 1; e_tag = "R4";
                e_l = p ? m_data[fr][off[2:0]] : d;
                e_r = p ? d : m_data[fr][off[2:0]];
                m_pres[fr][off[2:0]] = 0;
            end else begin
                e_col = 1; e_tag = "R5";
            end
        end
        if (fe) begin
            for (int s = 0; s < 8; s++) m_pres[ff][s] = 0;
            e_tag = {e_tag, "/R8"};
        end
    endfunction

    // Drive one cycle at the falling edge, check after the next falling edge.
    task automatic step(bit v, bit dy, bit p, logic [7:0] off, logic [1:0] fr,
                        logic [15:0] d, bit fe, logic [1:0] ff, string note);
        bit ok;
        in_valid = v; in_dyadic = dy; in_port = p; in_offset = off;
        in_frame = fr; in_data = d; free_valid = fe; free_frame = ff;
        model(v, dy, p, off, fr, d, fe, ff);
        @(posedge clk);
        @(negedge clk);
        ok = (out_valid == e_v) && (err_collision == e_col) && (err_offset == e_bad);
        if (e_v)
            ok = ok && (out_pair == e_pair) && (out_offset == e_off) &&
                 (out_frame == e_fr) && (out_left == e_l) && (out_right == e_r);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got v=%0b pair=%0b off=%0d fr=%0d l=%h r=%h col=%0b bad=%0b exp v=%0b pair=%0b off=%0d fr=%0d l=%h r=%h col=%0b bad=%0b",
                     e_tag, note, out_valid, out_pair, out_offset, out_frame, out_left,
                     out_right, err_collision, err_offset, e_v, e_pair, e_off, e_fr,
                     e_l, e_r, e_col, e_bad);
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R9 watchdog: got running exp finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0D1A_0BE7));
        rst_n = 0; in_valid = 0; in_dyadic = 0; in_port = 0; in_offset = 0;
        in_frame = 0; in_data = 0; free_valid = 0; free_frame = 0;
        for (int f = 0; f < 4; f++) for (int s = 0; s < 8; s++) m_pres[f][s] = 0;
        repeat (3) @(negedge clk);
        // R1: outputs idle in reset.
        checks++;
        if (out_valid || err_collision || err_offset) begin
            errors++;
            $display("FAIL R1 reset: got v=%0b col=%0b bad=%0b exp 0 0 0",
                     out_valid, err_collision, err_offset);
        end
        rst_n = 1;
        // R1: first operand after reset is stored silently.
        step(1, 1, 1, 8'd5, 2'd2, 16'h1234, 0, 0, "R1 empty after reset");
        step(1, 1, 0, 8'd5, 2'd2, 16'h4321, 0, 0, "R1 pair after reset");
        // R2: monadic at high offsets and at an offset with a waiting operand.
        step(1, 0, 0, 8'd200, 2'd1, 16'hBEEF, 0, 0, "R2 monadic 200");
        step(1, 1, 0, 8'd2, 2'd0, 16'h0202, 0, 0, "R3 park");
        step(1, 0, 1, 8'd2, 2'd0, 16'hCAFE, 0, 0, "R2 monadic ignores presence");
        step(1, 1, 1, 8'd2, 2'd0, 16'h2020, 0, 0, "R4 partner after monadic");
        // R4: port 1 first, port 0 second; last slot 7.
        step(1, 1, 1, 8'd7, 2'd3, 16'hAAAA, 0, 0, "R3 slot7");
        step(1, 1, 0, 8'd7, 2'd3, 16'h5555, 0, 0, "R4 reversed order");
        // R5: collision keeps the first operand.
        step(1, 1, 0, 8'd4, 2'd1, 16'h0001, 0, 0, "R3 park");
        step(1, 1, 0, 8'd4, 2'd1, 16'h0002, 0, 0, "R5 collision");
        step(1, 1, 1, 8'd4, 2'd1, 16'h0003, 0, 0, "R5 original kept");
        // R6: out-of-range dyadic offsets.
        step(1, 1, 0, 8'd8, 2'd0, 16'h0808, 0, 0, "R6 offset 8");
        step(1, 1, 1, 8'd255, 2'd0, 16'hFFFF, 0, 0, "R6 offset 255");
        step(1, 1, 1, 8'd0, 2'd0, 16'h0A0A, 0, 0, "R6 slot0 still empty");
        // R7: same offset, different frames.
        step(1, 1, 0, 8'd1, 2'd2, 16'h2222, 0, 0, "R7 frame2");
        step(1, 1, 1, 8'd1, 2'd3, 16'h3333, 0, 0, "R7 frame3 no pair");
        // R8: release frame 2, then its slot is empty.
        step(0, 0, 0, 8'd0, 2'd0, 16'h0, 1, 2'd2, "R8 free frame2");
        step(1, 1, 1, 8'd1, 2'd2, 16'h2223, 0, 0, "R8 stored after free");
        step(1, 1, 0, 8'd1, 2'd2, 16'h2224, 0, 0, "R8 pair after free");
        step(1, 1, 0, 8'd1, 2'd3, 16'h3334, 0, 0, "R7 frame3 pair");
        // R8: same-cycle store and release of the same frame.
        step(1, 1, 0, 8'd6, 2'd1, 16'h6666, 1, 2'd1, "R8 store+free");
        step(1, 1, 1, 8'd6, 2'd1, 16'h6667, 0, 0, "R8 store removed");
        // Random traffic.
        for (int i = 0; i < 4000; i++) begin
            bit          v  = ($urandom % 100) < 85;
            bit          dy = ($urandom % 100) < 80;
            bit          p  = $urandom % 2;
            logic [7:0]  o  = dy ? 8'($urandom % 10) : 8'($urandom % 256);
            logic [1:0]  fr = 2'($urandom % 4);
            logic [15:0] d  = 16'($urandom);
            bit          fe = ($urandom % 100) < 3;
            logic [1:0]  ff = 2'($urandom % 4);
            step(v, dy, p, o, fr, d, fe, ff, "random");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule